// File: doc/BRIEF.md
# Refresh-Hiding Pseudo-Static Memory Controller

This block puts an array of small dynamic memory banks behind a plain synchronous SRAM port. The port has an access request, a write enable, an address, write data and read data. There are no wait states. Read data appears one cycle after the read is presented. The user never sees a refresh or a row cycle. Every request is accepted in the cycle it is presented, even when requests come back to back.

Each bank row is modelled as a register row with an age counter. The age counter stands in for the charge a real cell would lose. Any bank that the user is not addressing uses its cycle to refresh. A round-robin pointer picks the row, and rows that were restored recently are skipped.

A row cache the size of one bank holds one row per row index and is tagged with the bank that row came from. A repeated access to a row that is already cached is served from the cache. The accessed bank is then free, and it refreshes another of its rows. A write that hits the cache marks the entry dirty. A dirty entry is written back to its own bank before the slot takes a row from a different bank.

Top module: `psram_ctrl`

## Requirements
- R1: After reset, `rd_data` is zero and every address reads back as zero.
- R2: The address is split as {bank, row, column}, with the column in the low bits. Column c selects bits [c*WORD_W +: WORD_W] of the row. A read presented in cycle n returns the last word written to that address on `rd_data` after the clock edge that ends cycle n.
- R3: Requests are accepted every cycle with no stall. Back-to-back writes and reads that alternate between banks all take effect.
- R4: No row goes RETAIN_CYC cycles without being restored. A row that reaches that age loses its contents and reads back as zero. Stored data therefore survives idle periods many times longer than RETAIN_CYC.
- R5: Repeated accesses to one cached row are served by the cache. The bank uses those cycles to refresh its other rows, so every other row of that bank keeps its data under sustained hammering.
- R6: Accesses confined to one bank that cycle through different rows return correct data. The row cycles of those accesses count as restores.
- R7: A write that hits the cache is held there, marked dirty. The entry reaches its own bank before the slot is refilled from another bank, so the value survives the eviction.
- R8: With the request low, nothing is written and `rd_data` holds its previous value. `rd_data` also holds across write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request for this cycle |
| we | input | 1 | 1 = write, 0 = read (when req is high) |
| addr | input | ADDR_W | {bank, row, column} word address |
| wr_data | input | WORD_W | Write word |
| rd_data | output | WORD_W | Read word, valid the cycle after a read |

## Verification
The bench builds the block with two banks of eight rows, 64-bit rows of four 16-bit words, and a retention limit of 64 cycles. With eight rows, cache slots alias between the two banks after only a few accesses, so dirty write-backs and evictions occur within a few cycles. A 64-cycle limit means that idle stretches and hammering runs of a few hundred cycles pass the retention deadline several times. Any gap in the refresh schedule then shows up as zeroed data when the words are read back against a flat reference memory.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_HIT  = 2'd1,
    ACC_MISS = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/psram_bank.sv
module psram_bank #(
  parameter int ROWS       = 128,
  parameter int ROW_W      = 256,
  parameter int RETAIN_CYC = 1024,
  parameter int SKIP_AGE   = 256,
  localparam int ROW_AW    = $clog2(ROWS),
  localparam int AGE_W     = $clog2(RETAIN_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_en,
  input  logic [ROW_AW-1:0] op_row,
  input  logic              op_wr,
  input  logic [ROW_W-1:0]  op_data,
  input  logic [ROW_AW-1:0] rd_idx,
  output logic [ROW_W-1:0]  rd_row,
  output logic              evt_restore,
  output logic              evt_refresh,
  output logic [ROW_AW-1:0] evt_row
);

  logic [ROW_W-1:0]  mem [ROWS];
  logic [AGE_W-1:0]  age [ROWS];
  logic [ROW_AW-1:0] ptr;
  logic              refresh_now;

  function automatic logic [ROW_AW-1:0] ptr_next(input logic [ROW_AW-1:0] p);
    return (p == ROW_AW'(ROWS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rd_row      = mem[rd_idx];
  assign refresh_now = !op_en && (age[ptr] >= AGE_W'(SKIP_AGE));
  assign evt_refresh = refresh_now;
  assign evt_restore = op_en || refresh_now;
  assign evt_row     = op_en ? op_row : ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
      for (int r = 0; r < ROWS; r++) begin
        mem[r] <= '0;
        age[r] <= '0;
      end
    end else begin
      if (!op_en) ptr <= ptr_next(ptr);
      for (int r = 0; r < ROWS; r++) begin
        if (op_en && op_row == ROW_AW'(r)) begin
          age[r] <= '0;
          if (op_wr) mem[r] <= op_data;
        end else if (refresh_now && ptr == ROW_AW'(r)) begin
          age[r] <= '0;
        end else if (age[r] == AGE_W'(RETAIN_CYC - 1)) begin
          age[r] <= AGE_W'(RETAIN_CYC);
          mem[r] <= '0;
        end else if (age[r] < AGE_W'(RETAIN_CYC)) begin
          age[r] <= age[r] + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/psram_row_cache.sv
module psram_row_cache #(
  parameter int ROWS    = 128,
  parameter int ROW_W   = 256,
  parameter int BANK_AW = 2,
  localparam int ROW_AW = $clog2(ROWS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ROW_AW-1:0]  rd_idx,
  output logic [ROW_W-1:0]   rd_data,
  output logic [BANK_AW-1:0] rd_tag,
  output logic               rd_valid,
  output logic               rd_dirty,
  input  logic               wr_en,
  input  logic [ROW_AW-1:0]  wr_idx,
  input  logic [ROW_W-1:0]   wr_data,
  input  logic [BANK_AW-1:0] wr_tag,
  input  logic               wr_dirty
);

  logic [ROW_W-1:0]   line [ROWS];
  logic [BANK_AW-1:0] tag  [ROWS];
  logic [ROWS-1:0]    valid;
  logic [ROWS-1:0]    dirty;

  assign rd_data  = line[rd_idx];
  assign rd_tag   = tag[rd_idx];
  assign rd_valid = valid[rd_idx];
  assign rd_dirty = dirty[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
      dirty <= '0;
    end else if (wr_en) begin
      valid[wr_idx] <= 1'b1;
      dirty[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      line[wr_idx] <= wr_data;
      tag[wr_idx]  <= wr_tag;
    end
  end

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl #(
  parameter int BANKS      = 4,
  parameter int ROWS       = 128,
  parameter int ROW_W      = 256,
  parameter int WORD_W     = 32,
  parameter int RETAIN_CYC = 1024,
  localparam int WPR       = ROW_W / WORD_W,
  localparam int COL_AW    = $clog2(WPR),
  localparam int ROW_AW    = $clog2(ROWS),
  localparam int BANK_AW   = $clog2(BANKS),
  localparam int ADDR_W    = BANK_AW + ROW_AW + COL_AW,
  localparam int SKIP_AGE  = RETAIN_CYC / 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data
);
  import psram_pkg::*;

  function automatic logic [WORD_W-1:0] word_get(input logic [ROW_W-1:0] row,
                                                 input logic [COL_AW-1:0] col);
    return row[col*WORD_W +: WORD_W];
  endfunction

  function automatic logic [ROW_W-1:0] word_put(input logic [ROW_W-1:0]  row,
                                                input logic [COL_AW-1:0] col,
                                                input logic [WORD_W-1:0] w);
    logic [ROW_W-1:0] r;
    r = row;
    r[col*WORD_W +: WORD_W] = w;
    return r;
  endfunction

  // address fields
  logic [COL_AW-1:0]  acc_col;
  logic [ROW_AW-1:0]  acc_row;
  logic [BANK_AW-1:0] acc_bank;
  assign acc_col  = addr[COL_AW-1:0];
  assign acc_row  = addr[COL_AW +: ROW_AW];
  assign acc_bank = addr[COL_AW + ROW_AW +: BANK_AW];

  // cache lookup
  logic [ROW_W-1:0]   c_data;
  logic [BANK_AW-1:0] c_tag;
  logic               c_valid, c_dirty;
  logic               acc_hit, victim_wb, c_wr_en, c_wr_dirty;
  acc_kind_e          kind;

  // bank-side wires brought out for the checker
  logic [ROW_W-1:0]        bank_rows [BANKS];
  logic [BANKS-1:0]        op_en;
  logic [BANKS-1:0]        evt_restore;
  logic [BANKS-1:0]        evt_refresh;
  logic [BANKS*ROW_AW-1:0] evt_row_flat;

  logic [ROW_W-1:0] src_row, new_row;

  assign acc_hit   = c_valid && (c_tag == acc_bank);
  assign kind      = !req ? ACC_IDLE : (acc_hit ? ACC_HIT : ACC_MISS);
  assign victim_wb = (kind == ACC_MISS) && c_valid && c_dirty;
  assign src_row   = acc_hit ? c_data : bank_rows[acc_bank];
  assign new_row   = we ? word_put(src_row, acc_col, wr_data) : src_row;

  assign c_wr_en    = (kind == ACC_MISS) || (kind == ACC_HIT && we);
  assign c_wr_dirty = (kind == ACC_HIT);

  psram_row_cache #(
    .ROWS(ROWS), .ROW_W(ROW_W), .BANK_AW(BANK_AW)
  ) cache_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (acc_row),
    .rd_data  (c_data),
    .rd_tag   (c_tag),
    .rd_valid (c_valid),
    .rd_dirty (c_dirty),
    .wr_en    (c_wr_en),
    .wr_idx   (acc_row),
    .wr_data  (new_row),
    .wr_tag   (acc_bank),
    .wr_dirty (c_wr_dirty)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic             is_user, is_wb;
    logic [ROW_W-1:0] op_data;
    logic [ROW_AW-1:0] ev_row;

    assign is_user  = (kind == ACC_MISS) && (acc_bank == BANK_AW'(b));
    assign is_wb    = victim_wb && (c_tag == BANK_AW'(b));
    assign op_en[b] = is_user || is_wb;
    assign op_data  = is_wb ? c_data : new_row;
    assign evt_row_flat[b*ROW_AW +: ROW_AW] = ev_row;

    psram_bank #(
      .ROWS(ROWS), .ROW_W(ROW_W), .RETAIN_CYC(RETAIN_CYC), .SKIP_AGE(SKIP_AGE)
    ) bank_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .op_en       (op_en[b]),
      .op_row      (acc_row),
      .op_wr       (is_wb || we),
      .op_data     (op_data),
      .rd_idx      (acc_row),
      .rd_row      (bank_rows[b]),
      .evt_restore (evt_restore[b]),
      .evt_refresh (evt_refresh[b]),
      .evt_row     (ev_row)
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else if (req && !we) rd_data <= word_get(src_row, acc_col);
  end

endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
  parameter int BANKS      = 4,
  parameter int ROWS       = 128,
  parameter int RETAIN_CYC = 1024,
  localparam int ROW_AW    = $clog2(ROWS),
  localparam int BANK_AW   = $clog2(BANKS),
  localparam int AGE_W     = $clog2(RETAIN_CYC + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req,
  input logic                    hit,
  input logic [BANK_AW-1:0]      acc_bank,
  input logic                    wb_en,
  input logic [BANK_AW-1:0]      wb_bank,
  input logic [BANKS-1:0]        bank_op,
  input logic [BANKS-1:0]        evt_restore,
  input logic [BANKS-1:0]        evt_refresh,
  input logic [BANKS*ROW_AW-1:0] evt_row_flat
);

  // independent age shadow, driven only by the restore events
  logic [AGE_W-1:0] shadow [BANKS*ROWS];
  logic             overdue;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BANKS*ROWS; i++) shadow[i] <= '0;
    end else begin
      for (int b = 0; b < BANKS; b++) begin
        for (int r = 0; r < ROWS; r++) begin
          if (evt_restore[b] && evt_row_flat[b*ROW_AW +: ROW_AW] == ROW_AW'(r))
            shadow[b*ROWS + r] <= '0;
          else if (shadow[b*ROWS + r] < AGE_W'(RETAIN_CYC))
            shadow[b*ROWS + r] <= shadow[b*ROWS + r] + 1'b1;
        end
      end
    end
  end

  always_comb begin
    overdue = 1'b0;
    for (int i = 0; i < BANKS*ROWS; i++)
      if (shadow[i] >= AGE_W'(RETAIN_CYC)) overdue = 1'b1;
  end

  a_r4_retention: assert property (@(posedge clk) disable iff (!rst_n)
    !overdue);

  a_r4_refresh_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_refresh & bank_op) == '0);

  a_r5_hit_frees_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (req && hit) |-> !bank_op[acc_bank]);

  a_r6_miss_restores_row: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !hit) |-> (bank_op[acc_bank] && evt_restore[acc_bank]));

  a_r7_writeback_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (evt_restore[wb_bank] && wb_bank != acc_bank));

  a_r3_bank_budget: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_op) <= 2);

endmodule

bind psram_ctrl psram_ctrl_chk #(
  .BANKS(BANKS), .ROWS(ROWS), .RETAIN_CYC(RETAIN_CYC)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .req          (req),
  .hit          (acc_hit),
  .acc_bank     (acc_bank),
  .wb_en        (victim_wb),
  .wb_bank      (c_tag),
  .bank_op      (op_en),
  .evt_restore  (evt_restore),
  .evt_refresh  (evt_refresh),
  .evt_row_flat (evt_row_flat)
);

// File: tb/psram_ctrl_tb.sv
module psram_ctrl_tb_top;
  localparam int BANKS = 2, ROWS = 8, ROW_W = 64, WORD_W = 16, RETAIN = 64;
  localparam int AW = 6;   // 1 bank bit, 3 row bits, 2 column bits
  localparam int NW = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic [WORD_W-1:0] wr_data = '0, rd_data;

  always #10 clk = ~clk;   // 50 MHz

  psram_ctrl #(.BANKS(BANKS), .ROWS(ROWS), .ROW_W(ROW_W), .WORD_W(WORD_W),
               .RETAIN_CYC(RETAIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data));

  int total = 0, bad = 0;
  logic [WORD_W-1:0] gold [NW];
  logic [WORD_W-1:0] exp_hold = '0;
  logic  chk_on = 1'b0, finished = 1'b0;
  string cur_rq = "R1";

  function automatic logic [AW-1:0] mk(int b, int r, int c);
    return AW'((b << 5) | (r << 2) | c);
  endfunction

  task automatic check(string rq, logic [WORD_W-1:0] got, logic [WORD_W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: rd_data=%h expected=%h at %0t", rq, got, exp, $time);
    end
  endtask

  // one cycle on the port: check last result, then drive this cycle
  task automatic cyc(logic r, logic w, logic [AW-1:0] a, logic [WORD_W-1:0] d);
    @(negedge clk);
    if (chk_on) check(cur_rq, rd_data, exp_hold);
    req = r; we = w; addr = a; wr_data = d;
    if (r && !w) exp_hold = gold[a];
    if (r && w) gold[a] = d;
  endtask

  task automatic t_reset;
    cur_rq = "R1";
    for (int i = 0; i < NW; i++) gold[i] = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1", rd_data, '0);
    chk_on = 1'b1;
    for (int i = 0; i < NW; i++) cyc(1, 0, AW'(i), '0);
  endtask

  task automatic t_fields;
    cur_rq = "R2";
    for (int i = 0; i < NW; i++) cyc(1, 1, AW'(i), WORD_W'(16'h1000 + i * 16'h0101));
    for (int c = 0; c < 4; c++) cyc(1, 0, mk(1, 5, c), '0);
    for (int i = NW - 1; i >= 0; i--) cyc(1, 0, AW'(i), '0);
  endtask

  task automatic t_b2b;
    cur_rq = "R3";
    for (int k = 0; k < 32; k++) cyc(1, 1, mk(k % 2, (k / 2) % 8, k % 4), WORD_W'(16'hA500 + k));
    for (int k = 0; k < 32; k++) cyc(1, 0, mk(k % 2, (k / 2) % 8, k % 4), '0);
    for (int k = 0; k < 16; k++) begin
      cyc(1, 1, mk(0, k % 8, 1), WORD_W'(16'h3C00 + k));
      cyc(1, 0, mk(0, k % 8, 1), '0);
    end
  endtask

  task automatic t_idle_hold;
    cur_rq = "R8";
    cyc(1, 0, mk(1, 2, 3), '0);
    cyc(0, 1, mk(1, 2, 3), 16'hDEAD);   // request low: no write
    cyc(0, 0, mk(0, 0, 0), '0);
    cyc(1, 1, mk(0, 4, 0), 16'h7777);   // write: rd_data holds
    cyc(1, 0, mk(1, 2, 3), '0);
  endtask

  task automatic t_long_idle;
    cur_rq = "R4";
    for (int k = 0; k < 5 * RETAIN; k++) cyc(0, 0, '0, '0);
    for (int i = 0; i < NW; i++) cyc(1, 0, AW'(i), '0);
  endtask

  task automatic t_hammer;
    cur_rq = "R5";
    for (int r = 0; r < ROWS; r++) cyc(1, 1, mk(0, r, 0), WORD_W'(16'hB000 + r));
    for (int k = 0; k < 5 * RETAIN; k++) cyc(1, k % 3 == 0, mk(0, 2, 0), WORD_W'(16'hC000 + k));
    for (int i = 0; i < NW; i++) cyc(1, 0, AW'(i), '0);
  endtask

  task automatic t_same_bank;
    cur_rq = "R6";
    for (int k = 0; k < 4 * RETAIN; k++) begin
      int r = (k * 3) % ROWS;
      cyc(1, k % 2 == 0, mk(1, r, k % 4), WORD_W'(16'hD000 + k));
    end
    for (int i = 0; i < NW; i++) cyc(1, 0, AW'(i), '0);
  endtask

  task automatic t_evict;
    cur_rq = "R7";
    for (int r = 0; r < ROWS; r++) begin
      cyc(1, 1, mk(0, r, 1), WORD_W'(16'hE100 + r));   // fill line from bank 0
      cyc(1, 1, mk(0, r, 2), WORD_W'(16'hE200 + r));   // hit: dirty
      cyc(1, 0, mk(1, r, 0), '0);                       // bank 1 reuses slot
      cyc(1, 0, mk(0, r, 2), '0);                       // comes back from bank 0
      cyc(1, 0, mk(0, r, 1), '0);
    end
  endtask

  task automatic t_random;
    cur_rq = "R3";
    for (int k = 0; k < 3000; k++) begin
      logic [AW-1:0] a;
      a = AW'($urandom % NW);
      if (k % 500 < 100) a[AW-1] = 1'b0;   // stretch on one bank
      cyc($urandom % 8 != 0, $urandom % 2 == 1, a, WORD_W'($urandom));
    end
    cur_rq = "R4";
    for (int i = 0; i < NW; i++) cyc(1, 0, AW'(i), '0);
  endtask

  initial begin
    void'($urandom(32'd91));
    t_reset;
    t_fields;
    t_b2b;
    t_idle_hold;
    t_long_idle;
    t_hammer;
    t_same_bank;
    t_evict;
    t_random;
    cyc(0, 0, '0, '0);
    cyc(0, 0, '0, '0);
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule